// File: doc/BRIEF.md
# Sixteen-Bit Output-Compare Timer with Master Override

A free-running up-counter is driven from the bus clock through a power-of-two prescaler. Eight channels sit beside it. A channel set to compare mode raises its match flag on the clock edge where the counter takes the value in that channel's compare register. On the same edge it applies a two-bit action to its own output pin: hold, toggle, drive low or drive high. The highest channel is also a master. When it matches, it forces every pin chosen by an override mask to the level held in an override data register, and that level beats any action another channel takes on the same edge. Software builds pulse trains by pairing the master with one other channel. The master's match drives the pin to one level, and the partner's action returns it to the other level.

Software reaches the block through a flat register bus. A write lands on the clock edge where `bus_wr` is high, and reads are combinational. Each channel's interrupt request is its match flag gated by an enable bit. Flags are cleared by writing ones to them.

Register offsets (5-bit address, 16-bit data; unmapped offsets read zero): 0x00 run control (bit 7 = run), 0x01 prescale code (bits 2:0), 0x02 channel mode (bit n = channel n), 0x03 match flags, 0x04 interrupt enables, 0x05 override mask, 0x06 override data, 0x07 action codes (channel n at bits 2n+1:2n), 0x08 counter, 0x10+n compare register of channel n.

Top module: `oc_timer`

## Requirements
- R1: The counter advances only while bit 7 of register 0x00 is 1. While that bit is 0, the counter holds its value.
- R2: With prescale code c in register 0x01, the counter advances once every 2^c clocks. Counting starts on the edge that writes the run bit, so k clocks later the counter reads floor(k / 2^c).
- R3: A write to 0x08 loads the counter and restarts the prescaler. The counter wraps from 0xFFFF to 0x0000.
- R4: A channel whose bit in register 0x02 is 0 never sets its flag and never moves its pin, whatever its compare value and action code.
- R5: For a channel whose mode bit is 1, flag bit n in 0x03 becomes 1 on the edge where the counter takes the value of compare register n. The flag is not set before that edge.
- R6: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged. A match on the same edge as a clearing write leaves the flag set.
- R7: On a match of channel n, its action code in 0x07 acts on pin n: 00 leaves the pin alone, 01 toggles it, 10 drives it low, 11 drives it high.
- R8: On a match of channel 7 in compare mode, every pin whose bit is 1 in 0x05 takes the matching bit of 0x06. Pins outside the mask are unaffected.
- R9: When channel 7 and another channel match on the same edge, the override value from R8 wins on pins inside the mask.
- R10: Interrupt request n equals flag bit n AND enable bit n of 0x04.
- R11: After reset, every register reads 0, and all pins and interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| pin_o | output | 8 | Channel output pins |
| irq_o | output | 8 | Per-channel interrupt requests |

## Verification
The bench uses the default parameters: a 16-bit counter, eight channels and a 3-bit prescale code. It sweeps every action code on every non-master channel against a bench model of the pins, and for each case it checks the flag on the cycle before the match and on the match cycle itself. Prescale codes 0, 1 and 2 are checked against floor division of the elapsed clock count. Three cases are reachable only with a few targeted loads: preloading 0xFFFE exercises the wrap, the master and a partner share a compare value to test override priority, and a clearing write is placed on the exact match edge to test flag set-versus-clear.

// File: rtl/oc_timer_pkg.sv
// Package: shared register offsets and the per-channel action encoding.
// Assumes a 5-bit register address space.
package oc_timer_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_RUN      = 5'h00;
    localparam logic [ADDR_W-1:0] A_PRE      = 5'h01;
    localparam logic [ADDR_W-1:0] A_MODE     = 5'h02;
    localparam logic [ADDR_W-1:0] A_FLAG     = 5'h03;
    localparam logic [ADDR_W-1:0] A_IEN      = 5'h04;
    localparam logic [ADDR_W-1:0] A_OMASK    = 5'h05;
    localparam logic [ADDR_W-1:0] A_ODATA    = 5'h06;
    localparam logic [ADDR_W-1:0] A_ACT      = 5'h07;
    localparam logic [ADDR_W-1:0] A_COUNT    = 5'h08;
    localparam logic [ADDR_W-1:0] A_CMP_BASE = 5'h10;

    // Pin action applied on a channel match
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } oc_act_e;

endpackage

// File: rtl/oc_timebase.sv
// Module: oc_timebase
// Prescaler and free-running up-counter. The counter advances on a tick,
// which occurs once every 2^pre_code clocks while run is high. A load
// replaces the count and restarts the prescaler. Assumes PS_W <= 4.
module oc_timebase #(
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PS_W-1:0]  pre_code,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             tick
);
    localparam int PC_W = (1 << PS_W) - 1;

    logic [PC_W-1:0] pcnt_q;
    logic [PC_W-1:0] pc_limit;

    // Terminal prescaler value for the selected division
    assign pc_limit = (PC_W'(1) << pre_code) - PC_W'(1);
    assign tick     = run && !load && (pcnt_q >= pc_limit);
    assign cnt_nxt  = cnt_q + CNT_W'(1);

    // Prescaler and counter state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            pcnt_q <= '0;
            cnt_q  <= load_val;
        end else if (tick) begin
            pcnt_q <= '0;
            cnt_q  <= cnt_nxt;
        end else if (run) begin
            pcnt_q <= pcnt_q + PC_W'(1);
        end
    end

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt_q));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/oc_regs.sv
// Module: oc_regs
// Register file: control, mode, enables, override pair, action codes,
// compare registers and write-one-to-clear match flags. Assumes
// 2*NCH <= CNT_W and NCH <= 16.
module oc_regs
    import oc_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 8,
    parameter int PS_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [CNT_W-1:0]           bus_wdata,
    input  logic [NCH-1:0]             match_i,
    input  logic [CNT_W-1:0]           cnt_i,
    output logic [CNT_W-1:0]           bus_rdata,
    output logic                       run_q,
    output logic [PS_W-1:0]            pre_q,
    output logic [NCH-1:0]             mode_q,
    output logic [NCH-1:0]             flag_q,
    output logic [NCH-1:0]             ien_q,
    output logic [NCH-1:0]             omask_q,
    output logic [NCH-1:0]             odata_q,
    output logic [2*NCH-1:0]           act_q,
    output logic [NCH-1:0][CNT_W-1:0]  cmp_q,
    output logic                       load,
    output logic [CNT_W-1:0]           load_val
);
    localparam int RUN_BIT = 7;

    logic           flag_wr;
    logic [NCH-1:0] flag_clr;

    assign load     = bus_wr && (bus_addr == A_COUNT);
    assign load_val = bus_wdata;
    assign flag_wr  = bus_wr && (bus_addr == A_FLAG);
    assign flag_clr = flag_wr ? bus_wdata[NCH-1:0] : '0;

    // Control and configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            pre_q   <= '0;
            mode_q  <= '0;
            ien_q   <= '0;
            omask_q <= '0;
            odata_q <= '0;
            act_q   <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_RUN:   run_q   <= bus_wdata[RUN_BIT];
                A_PRE:   pre_q   <= bus_wdata[PS_W-1:0];
                A_MODE:  mode_q  <= bus_wdata[NCH-1:0];
                A_IEN:   ien_q   <= bus_wdata[NCH-1:0];
                A_OMASK: omask_q <= bus_wdata[NCH-1:0];
                A_ODATA: odata_q <= bus_wdata[NCH-1:0];
                A_ACT:   act_q   <= bus_wdata[2*NCH-1:0];
                default: ;
            endcase
        end
    end

    // Match flags: a match sets, a written one clears, setting wins
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~flag_clr) | match_i;
    end

    // One compare register per channel
    for (genvar n = 0; n < NCH; n++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmp_q[n] <= '0;
            else if (bus_wr && (bus_addr == A_CMP_BASE + ADDR_W'(n)))
                cmp_q[n] <= bus_wdata;
        end
    end

    // Combinational read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_RUN:   bus_rdata[RUN_BIT] = run_q;
            A_PRE:   bus_rdata = CNT_W'(pre_q);
            A_MODE:  bus_rdata = CNT_W'(mode_q);
            A_FLAG:  bus_rdata = CNT_W'(flag_q);
            A_IEN:   bus_rdata = CNT_W'(ien_q);
            A_OMASK: bus_rdata = CNT_W'(omask_q);
            A_ODATA: bus_rdata = CNT_W'(odata_q);
            A_ACT:   bus_rdata = CNT_W'(act_q);
            A_COUNT: bus_rdata = cnt_i;
            default: begin
                for (int n = 0; n < NCH; n++)
                    if (bus_addr == A_CMP_BASE + ADDR_W'(n))
                        bus_rdata = cmp_q[n];
            end
        endcase
    end

    // R6
    flag_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flag_q) & ~flag_q)) |-> $past(flag_wr));

    // R5
    flag_set_by_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_q & ~$past(flag_q))) |-> (|$past(match_i)));

endmodule

// File: rtl/oc_pins.sv
// Module: oc_pins
// Output pin registers. Each matching channel applies its action code to
// its own pin; a match of the top channel then forces the masked pins to
// the override data, which takes priority.
module oc_pins
    import oc_timer_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   match_i,
    input  logic [2*NCH-1:0] act_i,
    input  logic [NCH-1:0]   omask_i,
    input  logic [NCH-1:0]   odata_i,
    output logic [NCH-1:0]   pin_q
);
    localparam int MASTER = NCH - 1;

    logic ovr_hit;
    assign ovr_hit = match_i[MASTER];

    for (genvar n = 0; n < NCH; n++) begin : g_pin
        oc_act_e act_n;
        assign act_n = oc_act_e'(act_i[2*n +: 2]);

        // Pin update: override first, then the channel's own action
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pin_q[n] <= 1'b0;
            end else if (ovr_hit && omask_i[n]) begin
                pin_q[n] <= odata_i[n];
            end else if (match_i[n]) begin
                case (act_n)
                    ACT_TOGGLE: pin_q[n] <= ~pin_q[n];
                    ACT_LOW:    pin_q[n] <= 1'b0;
                    ACT_HIGH:   pin_q[n] <= 1'b1;
                    default:    ;
                endcase
            end
        end

        // R8
        ovr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ovr_hit && omask_i[n]) |=> (pin_q[n] == $past(odata_i[n])));

        // R7
        pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!match_i[n] && !(ovr_hit && omask_i[n])) |=> $stable(pin_q[n]));
    end

endmodule

// File: rtl/oc_timer.sv
// Module: oc_timer (top)
// Output-compare timer: time base, register file, per-channel equality
// comparators and pin logic. A channel matches when the counter is about
// to take its compare value on a tick and the channel is in compare mode.
module oc_timer
    import oc_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 8,
    parameter int PS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    pin_o,
    output logic [NCH-1:0]    irq_o
);
    logic                      run_q;
    logic [PS_W-1:0]           pre_q;
    logic [NCH-1:0]            mode_q;
    logic [NCH-1:0]            flag_q;
    logic [NCH-1:0]            ien_q;
    logic [NCH-1:0]            omask_q;
    logic [NCH-1:0]            odata_q;
    logic [2*NCH-1:0]          act_q;
    logic [NCH-1:0][CNT_W-1:0] cmp_q;
    logic                      load;
    logic [CNT_W-1:0]          load_val;
    logic [CNT_W-1:0]          cnt_q;
    logic [CNT_W-1:0]          cnt_nxt;
    logic                      tick;
    logic [NCH-1:0]            match;

    oc_timebase #(.CNT_W(CNT_W), .PS_W(PS_W)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .pre_code (pre_q),
        .load     (load),
        .load_val (load_val),
        .cnt_q    (cnt_q),
        .cnt_nxt  (cnt_nxt),
        .tick     (tick)
    );

    oc_regs #(.CNT_W(CNT_W), .NCH(NCH), .PS_W(PS_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .match_i   (match),
        .cnt_i     (cnt_q),
        .bus_rdata (bus_rdata),
        .run_q     (run_q),
        .pre_q     (pre_q),
        .mode_q    (mode_q),
        .flag_q    (flag_q),
        .ien_q     (ien_q),
        .omask_q   (omask_q),
        .odata_q   (odata_q),
        .act_q     (act_q),
        .cmp_q     (cmp_q),
        .load      (load),
        .load_val  (load_val)
    );

    // Per-channel comparator against the value the counter is about to take
    for (genvar n = 0; n < NCH; n++) begin : g_match
        assign match[n] = tick && mode_q[n] && (cmp_q[n] == cnt_nxt);
    end

    oc_pins #(.NCH(NCH)) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .match_i (match),
        .act_i   (act_q),
        .omask_i (omask_q),
        .odata_i (odata_q),
        .pin_q   (pin_o)
    );

    assign irq_o = flag_q & ien_q;

    // R4
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(~mode_q) & flag_q & ~$past(flag_q))) == 1'b0);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_o & ~ien_q)) == 1'b0);

endmodule

// File: tb/oc_timer_bench.sv
module oc_timer_bench;
    import oc_timer_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  pin_o;
    logic [7:0]  irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [7:0] exp_pin = '0;
    logic [15:0] v;

    always #10 clk = ~clk;

    oc_timer u_oc_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_o(pin_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [4:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    // Stop, load count, then start; returns at the negedge after the run edge
    task automatic start_at(input logic [15:0] c, input logic [2:0] pre);
        bw(A_RUN, 16'h0000);
        bw(A_PRE, {13'd0, pre});
        bw(A_COUNT, c);
        bw(A_RUN, 16'h0080);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        for (int a = 0; a < 9; a++) begin
            rd(5'(a), v);
            chk("R11 reg", int'(v), 0);
        end
        chk("R11 pins", int'(pin_o), 0);
        chk("R11 irq", int'(irq_o), 0);

        // R2: prescale codes 0..2, count = floor(k / 2^c)
        for (int c = 0; c < 3; c++) begin
            start_at(16'h0000, 3'(c));
            wait_cyc(10);
            rd(A_COUNT, v);
            chk("R2 prescale", int'(v), 10 >> c);
        end

        // R1: counter holds while run bit is 0
        bw(A_RUN, 16'h0000);
        rd(A_COUNT, v);
        begin
            logic [15:0] held;
            held = v;
            wait_cyc(12);
            rd(A_COUNT, v);
            chk("R1 hold", int'(v), int'(held));
        end

        // R7/R5/R6: every action code on every non-master channel
        for (int n = 0; n < 7; n++) begin
            for (int a = 0; a < 4; a++) begin
                bw(A_RUN, 16'h0000);
                bw(A_MODE, 16'(1 << n));
                bw(A_ACT, 16'(a << (2 * n)));
                bw(A_CMP_BASE + 5'(n), 16'd20);
                start_at(16'h0000, 3'd0);
                wait_cyc(19);
                rd(A_FLAG, v);
                chk("R5 before match", int'(v[n]), 0);
                wait_cyc(1);
                rd(A_FLAG, v);
                chk("R5 at match", int'(v[n]), 1);
                case (a)
                    1: exp_pin[n] = ~exp_pin[n];
                    2: exp_pin[n] = 1'b0;
                    3: exp_pin[n] = 1'b1;
                    default: ;
                endcase
                chk("R7 pin", int'(pin_o), int'(exp_pin));
                bw(A_RUN, 16'h0000);
                bw(A_FLAG, 16'h0000);
                rd(A_FLAG, v);
                chk("R6 write zero", int'(v[n]), 1);
                bw(A_FLAG, 16'(1 << n));
                rd(A_FLAG, v);
                chk("R6 write one", int'(v), 0);
            end
        end

        // R4: channel 2 in capture mode with action low: nothing changes
        bw(A_MODE, 16'h0000);
        bw(A_ACT, 16'(2 << 4));
        bw(A_CMP_BASE + 5'd2, 16'd10);
        start_at(16'h0000, 3'd0);
        wait_cyc(15);
        rd(A_FLAG, v);
        chk("R4 flag", int'(v), 0);
        chk("R4 pin", int'(pin_o), int'(exp_pin));

        // R3: wrap from 0xFFFE through 0xFFFF to 0, channel 0 matches at 0
        bw(A_RUN, 16'h0000);
        bw(A_ACT, 16'h0000);
        bw(A_MODE, 16'h0001);
        bw(A_CMP_BASE, 16'h0000);
        start_at(16'hFFFE, 3'd0);
        wait_cyc(2);
        rd(A_COUNT, v);
        chk("R3 wrap count", int'(v), 0);
        rd(A_FLAG, v);
        chk("R3 wrap match", int'(v), 1);
        bw(A_RUN, 16'h0000);

        // R6: clearing write lands on the match edge, flag stays set
        bw(A_CMP_BASE, 16'd5);
        start_at(16'h0000, 3'd0);
        wait_cyc(4);
        bw(A_FLAG, 16'h0001);
        rd(A_FLAG, v);
        chk("R6 set wins", int'(v), 1);
        bw(A_RUN, 16'h0000);
        bw(A_FLAG, 16'h00FF);

        // R8/R9: master and channel 1 match together
        bw(A_MODE, 16'h0082);
        bw(A_ACT, 16'(3 << 2));
        bw(A_CMP_BASE + 5'd1, 16'd30);
        bw(A_CMP_BASE + 5'd7, 16'd30);
        bw(A_OMASK, 16'h000F);
        bw(A_ODATA, 16'h0005);
        start_at(16'h0000, 3'd0);
        wait_cyc(30);
        exp_pin[3:0] = 4'b0101;
        chk("R8 override pins", int'(pin_o), int'(exp_pin));
        chk("R9 override priority", int'(pin_o[1]), 0);
        rd(A_FLAG, v);
        chk("R5 both flags", int'(v), 16'h0082);
        bw(A_RUN, 16'h0000);

        // R10: irq = flag & enable
        bw(A_IEN, 16'h0080);
        chk("R10 irq master", int'(irq_o), 8'h80);
        bw(A_IEN, 16'h00F0);
        chk("R10 irq mixed", int'(irq_o), 8'h80);
        bw(A_IEN, 16'h0003);
        chk("R10 irq low", int'(irq_o), 8'h02);
        bw(A_FLAG, 16'h0002);
        chk("R10 irq after clear", int'(irq_o), 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule